// File: doc/BRIEF.md
# Registered Command Fan-Out Buffer with Parity Check

This block registers memory command and address signals and sends each one out twice, as an A copy and a B copy. The two copies let one driver stage feed two loads. It captures 22 address/command data bits, two chip-select bits, two clock-enable bits and two termination-control bits on the rising clock edge.

The data outputs can hold their value on cycles where no rank is selected. A gate-enable input controls this holding. When the gate-enable input is tied low, the data outputs load on every edge.

A parity checker uses the parity bit sent alongside the data bits. It reports a mismatch on a registered, active-low error flag. An asynchronous active-low reset clears every register at once. The reset takes priority over the gating.

Top module: `cmd_fanout_reg`

## Requirements
- R1: Every registered output is driven as two identical copies: `q_a`/`q_b`, `cs_a`/`cs_b`, `cke_a`/`cke_b` and `odt_a`/`odt_b`.
- R2: While `rst_n` is low, all data, chip-select, clock-enable and termination outputs are 0. They reach 0 as soon as `rst_n` falls, with no clock edge needed.
- R3: While `rst_n` is low, `err_n` is 1. This holds even when the gating condition of R4 is present.
- R4: The chip-select inputs are active low: a value of 0 selects a rank. When `gate_en` is 1 and both `cs_n_in` bits are 1 at a rising edge, `q_a`/`q_b` keep their previous value.
- R5: When at least one `cs_n_in` bit is 0 at a rising edge, `q_a`/`q_b` take the value of `din` at that edge.
- R6: When `gate_en` is 0, `q_a`/`q_b` take the value of `din` at every rising edge, whatever the chip selects are.
- R7: Parity is even over `din` together with `par_in`. If data is captured at edge k, `err_n` after edge k+1 is 0 when the XOR of all 22 `din` bits and `par_in` is 1. It is 1 when that XOR is 0.
- R8: `cs_a`/`cs_b`, `cke_a`/`cke_b` and `odt_a`/`odt_b` take `cs_n_in`, `cke_in` and `odt_in` at every rising edge. Gating never holds them.
- R9: The parity check takes part only for edges where at least one `cs_n_in` bit is 0. If both bits are 1 at edge k, then `err_n` keeps its value at edge k+1.
- R10: After `rst_n` rises, all outputs keep their reset values until the first rising edge. That edge loads the inputs present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1 enables holding the data outputs when no chip select is active |
| din | input | 22 | Address/command data bits |
| par_in | input | 1 | Parity bit from the controller |
| cs_n_in | input | 2 | Active-low chip selects |
| cke_in | input | 2 | Clock-enable bits |
| odt_in | input | 2 | Termination-control bits |
| q_a | output | 22 | Registered data, copy A |
| q_b | output | 22 | Registered data, copy B |
| cs_a | output | 2 | Registered chip selects, copy A |
| cs_b | output | 2 | Registered chip selects, copy B |
| cke_a | output | 2 | Registered clock enables, copy A |
| cke_b | output | 2 | Registered clock enables, copy B |
| odt_a | output | 2 | Registered termination controls, copy A |
| odt_b | output | 2 | Registered termination controls, copy B |
| err_n | output | 1 | Registered active-low parity error flag |

## Verification
The bench builds the block with its default parameters: 22 data bits and two bits each for chip select, clock enable and termination. With these values every combination of the two chip selects and the gate enable is reached many times under random stimulus.

Random data drives both parity polarities. Directed phases cover long holds with both selects high, mid-cycle reset while the block is gated, and the first edge after reset release.

// File: rtl/cmd_fanout_reg.sv
module cmd_fanout_reg #(
  parameter int DW   = 22,
  parameter int NCS  = 2,
  parameter int NCKE = 2,
  parameter int NODT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_en,
  input  logic [DW-1:0]   din,
  input  logic            par_in,
  input  logic [NCS-1:0]  cs_n_in,
  input  logic [NCKE-1:0] cke_in,
  input  logic [NODT-1:0] odt_in,
  output logic [DW-1:0]   q_a,
  output logic [DW-1:0]   q_b,
  output logic [NCS-1:0]  cs_a,
  output logic [NCS-1:0]  cs_b,
  output logic [NCKE-1:0] cke_a,
  output logic [NCKE-1:0] cke_b,
  output logic [NODT-1:0] odt_a,
  output logic [NODT-1:0] odt_b,
  output logic            err_n
);
  localparam int COPIES = 2;

  logic any_sel, load;
  assign any_sel = ~&cs_n_in;
  assign load    = any_sel | ~gate_en;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [DW-1:0]   q;
    logic [NCS-1:0]  cs;
    logic [NCKE-1:0] cke;
    logic [NODT-1:0] odt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q   <= '0;
        cs  <= '0;
        cke <= '0;
        odt <= '0;
      end else begin
        if (load) q <= din;
        cs  <= cs_n_in;
        cke <= cke_in;
        odt <= odt_in;
      end
    end
  end

  assign q_a   = g_copy[0].q;
  assign q_b   = g_copy[1].q;
  assign cs_a  = g_copy[0].cs;
  assign cs_b  = g_copy[1].cs;
  assign cke_a = g_copy[0].cke;
  assign cke_b = g_copy[1].cke;
  assign odt_a = g_copy[0].odt;
  assign odt_b = g_copy[1].odt;

  logic chk_q, odd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= 1'b0;
      odd_q <= 1'b0;
      err_n <= 1'b1;
    end else begin
      chk_q <= any_sel;
      if (any_sel) odd_q <= ^{din, par_in};
      if (chk_q)   err_n <= ~odd_q;
    end
  end
endmodule

// File: rtl/cmd_fanout_reg_chk.sv
module cmd_fanout_reg_chk #(
  parameter int DW   = 22,
  parameter int NCS  = 2,
  parameter int NCKE = 2,
  parameter int NODT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gate_en,
  input logic [DW-1:0]   din,
  input logic            par_in,
  input logic [NCS-1:0]  cs_n_in,
  input logic [NCKE-1:0] cke_in,
  input logic [NODT-1:0] odt_in,
  input logic [DW-1:0]   q_a,
  input logic [DW-1:0]   q_b,
  input logic [NCS-1:0]  cs_a,
  input logic [NCS-1:0]  cs_b,
  input logic [NCKE-1:0] cke_a,
  input logic [NCKE-1:0] cke_b,
  input logic [NODT-1:0] odt_a,
  input logic [NODT-1:0] odt_b,
  input logic            err_n
);
  a_r1_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    (q_a == q_b) && (cs_a == cs_b) && (cke_a == cke_b) && (odt_a == odt_b));

  a_r4_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && (&cs_n_in)) |=> $stable(q_a));

  a_r5_selected_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n_in) |=> (q_a == $past(din)));

  a_r6_ungated_load: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (q_b == $past(din)));

  a_r8_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cs_a == $past(cs_n_in)) && (cke_b == $past(cke_in)) && (odt_a == $past(odt_in)));

  a_r7_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cs_n_in) |=> ##1 (err_n == !$past(^{din, par_in}, 2)));

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_in) |=> ##1 $stable(err_n));
endmodule

bind cmd_fanout_reg cmd_fanout_reg_chk #(.DW(DW), .NCS(NCS), .NCKE(NCKE), .NODT(NODT)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .din(din), .par_in(par_in),
  .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in),
  .q_a(q_a), .q_b(q_b), .cs_a(cs_a), .cs_b(cs_b), .cke_a(cke_a), .cke_b(cke_b),
  .odt_a(odt_a), .odt_b(odt_b), .err_n(err_n));

// File: tb/sim_cmd_fanout_reg.sv
module sim_cmd_fanout_reg;
  localparam int DW = 22;

  logic clk = 0, rst_n = 0, gate_en = 1, par_in = 0;
  logic [DW-1:0] din = '0;
  logic [1:0] cs_n_in = 2'b11, cke_in = '0, odt_in = '0;
  logic [DW-1:0] q_a, q_b;
  logic [1:0] cs_a, cs_b, cke_a, cke_b, odt_a, odt_b;
  logic err_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_q;
  logic [1:0] m_cs, m_cke, m_odt;
  logic m_v, m_p, m_err;

  cmd_fanout_reg u0 (.clk(clk), .rst_n(rst_n), .gate_en(gate_en), .din(din), .par_in(par_in),
    .cs_n_in(cs_n_in), .cke_in(cke_in), .odt_in(odt_in), .q_a(q_a), .q_b(q_b),
    .cs_a(cs_a), .cs_b(cs_b), .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a), .odt_b(odt_b),
    .err_n(err_n));

  always #2 clk = ~clk;

  function automatic logic odd_parity(logic [DW-1:0] d, logic p);
    logic r = p;
    for (int i = 0; i < DW; i++) r ^= d[i];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_q = '0; m_cs = '0; m_cke = '0; m_odt = '0; m_v = 0; m_p = 0; m_err = 1;
  endtask

  task automatic check_all();
    chk("R1 data copies", 32'(q_b), 32'(q_a));
    chk("R1 ctrl copies", {26'd0, cs_b, cke_b, odt_b}, {26'd0, cs_a, cke_a, odt_a});
    chk("R5/R4/R6 data", 32'(q_a), 32'(m_q));
    chk("R8 ctrl", {26'd0, cs_a, cke_a, odt_a}, {26'd0, m_cs, m_cke, m_odt});
    chk("R7/R9 err_n", 32'(err_n), 32'(m_err));
  endtask

  task automatic step(logic ge, logic [1:0] cs, logic [DW-1:0] d, logic p);
    @(negedge clk);
    gate_en = ge; cs_n_in = cs; din = d; par_in = p;
    cke_in = 2'($urandom); odt_in = 2'($urandom);
    @(posedge clk);
    if (m_v) m_err = ~m_p;
    m_v = ~&cs;
    if (~&cs) m_p = odd_parity(d, p);
    if ((~&cs) || !ge) m_q = d;
    m_cs = cs; m_cke = cke_in; m_odt = odt_in;
    #1 check_all();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_v;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset data", 32'(q_a), 0);
    chk("R2 reset ctrl", {26'd0, cs_a, cke_b, odt_a}, 0);
    chk("R3 reset err_n", 32'(err_n), 1);
    @(negedge clk);
    din = 22'h2AAAAA; cs_n_in = 2'b10; gate_en = 0;
    rst_n = 1;
    #1 chk("R10 low after release", 32'(q_a), 0);
    chk("R10 err after release", 32'(err_n), 1);
    @(posedge clk);
    m_q = din; m_cs = cs_n_in; m_v = 1; m_p = odd_parity(din, par_in);
    #1 chk("R10 first edge loads", 32'(q_b), 32'(din));

    step(1, 2'b01, 22'h000001, 0);
    step(1, 2'b01, 22'h000001, 1);
    step(1, 2'b01, 22'h000000, 0);
    hold_v = 22'h155555;
    step(1, 2'b10, hold_v, 1);
    for (int i = 0; i < 5; i++) step(1, 2'b11, 22'($urandom), 1'($urandom));
    chk("R4 long hold", 32'(q_a), 32'(hold_v));
    chk("R9 err held", 32'(err_n), 32'(m_err));
    step(0, 2'b11, 22'h3FFFFF, 0);
    step(0, 2'b11, 22'h123456, 1);

    step(1, 2'b11, 22'h0F0F0F, 0);
    @(negedge clk);
    #1 rst_n = 0;
    #0.5 model_reset();
    chk("R2 async clear", 32'(q_a), 0);
    chk("R3 gated reset err", 32'(err_n), 1);
    @(posedge clk);
    #1 chk("R3 reset wins gating", 32'(q_b), 0);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] cs = 2'($urandom);
      if ($urandom % 3 == 0) cs = 2'b11;
      step(($urandom % 5) != 0, cs, 22'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule